// File: doc/BRIEF.md
# MDIO Management Bus Controller

This block is a host-programmable master for the clause-22 MII management bus. It drives the MDC clock and two MDIO ports, one of which is selected at a time. A small register port gives software access to three ways of running the bus.

In frame mode, software writes one 32-bit command word. The controller sends a 32-bit preamble of ones and then the word, most significant bit first. For a read, it releases the line at the turnaround and captures the 16 data bits the PHY returns. In poll mode, the controller reads one PHY register over and over. It keeps a live image of that register, sets a sticky change bit for every bit that differs between successive results, and raises an interrupt for change bits that are not masked. In bit-bang mode, software registers drive MDC, the outgoing bit and the output enable of the selected port directly.

Host register addresses are: 0 command, 1 configuration, 2 poll status, 3 poll mask, 4 bit-bang clock, 5 bit-bang data and 6 bit-bang output enable. Host reads are combinational. Writes and read side effects take effect at the clock edge on which `host_wr` or `host_rd` is sampled high.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset, the command register reads 0x00010000 (bit 16, the done flag, is set) and the mask register reads 0xFFFF. MDC is low, both output enables are low and the interrupt is low.
- R2: A command word with opcode [29:28] = 01 is sent on the selected port as 32 ones followed by the 32-bit word, MSB first. Bit 16 of the command register reads 0 from the write until the transaction ends, and then reads 1.
- R3: A command word with opcode 10 drives the line up to and including the register address [22:18]. The enable is off from the first turnaround bit to the end. The 16 bits sampled on the MDC rising edges of the data phase are returned in command bits [15:0], with bit 16 set.
- R4: While a frame is in progress, the outgoing bit changes only on an MDC falling edge. Input bits are sampled on MDC rising edges.
- R5: While a frame is in progress, MDC has a period of 2*HALF_DIV clock cycles. In frame mode with no frame in progress, MDC is low.
- R6: Only the port chosen by configuration bit 0 is ever driven. The other port's enable is 0 and its data output is 1.
- R7: Configuration bit 1 enables polling in frame mode. The controller then repeatedly reads register [7:3] of PHY [14:10], and poll status bits [31:16] hold the last result.
- R8: Poll status bits [15:0] set for each bit that differs between consecutive poll results. The first result after polling is enabled sets none. A read of poll status returns these bits and clears them.
- R9: The interrupt is high exactly when some change bit is set whose mask bit is 0. A mask bit of 1 suppresses that bit.
- R10: A command written while a poll is running starts once that poll ends, before any further poll.
- R11: With configuration bit 2 set, MDC follows the bit-bang clock register, and the selected port's data and enable follow their bit-bang registers. A written command waits, with bit 16 at 0, until frame mode returns and then runs.
- R12: Configuration bits 8 and 9 read the live input levels of port 0 and port 1. Writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears poll change bits) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Unmasked poll change interrupt |
| mdc | output | 1 | Management clock |
| mdio_i | input | 2 | Input levels of MDIO ports 0 and 1 |
| mdio_o | output | 2 | Outgoing data of MDIO ports 0 and 1 |
| mdio_oe | output | 2 | Driver enables of MDIO ports 0 and 1 |

## Verification
The assertions assume that software does not change the port select, or the mode, while a frame is in progress. They also assume that a new command is written only after the done flag of the previous one has been seen. The stimulus waits on bit 16 before every new command, and it changes the configuration only after polling has been switched off and the bus has drained. The modelled PHY changes its data only on the system clock edge opposite to the one the controller uses. It latches each register value at the start of the turnaround, so a poll result is never a mix of two values.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
   localparam int HOST_AW   = 3;
   localparam int FRAME_W   = 32;
   localparam int DATA_W    = 16;
   localparam int N_PORTS   = 2;
   // bit offsets inside the frame, counted from its first bit
   localparam int TA_OFFSET   = 14;
   localparam int DATA_OFFSET = 16;
   localparam int DONE_BIT    = 16;

   localparam logic [1:0] START_CODE = 2'b01;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] TA_CODE    = 2'b10;

   localparam logic [HOST_AW-1:0] A_CMD   = 3'd0;
   localparam logic [HOST_AW-1:0] A_CFG   = 3'd1;
   localparam logic [HOST_AW-1:0] A_PSTAT = 3'd2;
   localparam logic [HOST_AW-1:0] A_PMASK = 3'd3;
   localparam logic [HOST_AW-1:0] A_BBCLK = 3'd4;
   localparam logic [HOST_AW-1:0] A_BBDAT = 3'd5;
   localparam logic [HOST_AW-1:0] A_BBOE  = 3'd6;

   function automatic logic [FRAME_W-1:0] poll_frame(input logic [4:0] phy, input logic [4:0] ra);
      return {START_CODE, OP_READ, phy, ra, TA_CODE, {DATA_W{1'b0}}};
   endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic fall
);
   logic tick;
   logic mdc_q;

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_nodiv
      assign tick = run;
   end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt_q <= '0;
         else if (!run || tick)    cnt_q <= '0;
         else                      cnt_q <= cnt_q + 1'b1;
      end
      assign tick = run && (cnt_q == CNT_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mdc_q <= 1'b0;
      else if (!run)   mdc_q <= 1'b0;
      else if (tick)   mdc_q <= ~mdc_q;
   end

   assign mdc  = mdc_q;
   assign rise = tick && !mdc_q;
   assign fall = tick && mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
   import mdio_pkg::*;
#(
   parameter int HALF_DIV = 2,
   parameter int PRE_BITS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] cmd_word,
   input  logic               sdi,
   output logic               busy,
   output logic               done,
   output logic [DATA_W-1:0]  rd_data,
   output logic               sdo,
   output logic               sdo_en,
   output logic               mdc
);
   localparam int TOTAL = PRE_BITS + FRAME_W;
   localparam int IDX_W = $clog2(TOTAL);
   localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(TOTAL - 1);
   localparam logic [IDX_W-1:0] RELEASE_IDX = IDX_W'(PRE_BITS + TA_OFFSET);
   localparam logic [IDX_W-1:0] CAPTURE_IDX = IDX_W'(PRE_BITS + DATA_OFFSET);

   if (PRE_BITS < 1) begin : g_bad_pre
      $error("PRE_BITS must be at least 1");
   end

   logic [TOTAL-1:0]  sreg_q;
   logic [IDX_W-1:0]  idx_q;
   logic              busy_q, rd_q, done_q;
   logic [DATA_W-1:0] sh_q;
   logic              rise, fall;

   mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy_q),
      .mdc  (mdc),
      .rise (rise),
      .fall (fall)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '1;
         idx_q  <= '0;
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
         done_q <= 1'b0;
         sh_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (start && !busy_q) begin
            sreg_q <= {{PRE_BITS{1'b1}}, cmd_word};
            idx_q  <= '0;
            busy_q <= 1'b1;
            rd_q   <= (cmd_word[29:28] == OP_READ);
         end else if (busy_q) begin
            if (rise && rd_q && idx_q >= CAPTURE_IDX)
               sh_q <= {sh_q[DATA_W-2:0], sdi};
            if (fall) begin
               if (idx_q == LAST_IDX) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  idx_q  <= idx_q + 1'b1;
                  sreg_q <= {sreg_q[TOTAL-2:0], 1'b1};
               end
            end
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign rd_data = sh_q;
   assign sdo     = busy_q ? sreg_q[TOTAL-1] : 1'b1;
   assign sdo_en  = busy_q && !(rd_q && idx_q >= RELEASE_IDX);
endmodule

// File: rtl/mdio_poll_trk.sv
`timescale 1ns/1ps
module mdio_poll_trk #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          res_valid,
   input  logic [DW-1:0] res_data,
   input  logic          clr_rd,
   output logic [DW-1:0] image,
   output logic [DW-1:0] chg
);
   logic [DW-1:0] image_q, chg_q, new_bits;
   logic          seen_q;

   assign new_bits = (res_valid && seen_q) ? (image_q ^ res_data) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         image_q <= '0;
         chg_q   <= '0;
         seen_q  <= 1'b0;
      end else begin
         chg_q <= (clr_rd ? '0 : chg_q) | new_bits;
         if (res_valid) begin
            image_q <= res_data;
            seen_q  <= enable;
         end else if (!enable) begin
            seen_q  <= 1'b0;
         end
      end
   end

   assign image = image_q;
   assign chg   = chg_q;
endmodule

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
   import mdio_pkg::*;
#(
   parameter int HALF_DIV = 2,
   parameter int PRE_BITS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   output logic               irq,
   output logic               mdc,
   input  logic [N_PORTS-1:0] mdio_i,
   output logic [N_PORTS-1:0] mdio_o,
   output logic [N_PORTS-1:0] mdio_oe
);
   logic [FRAME_W-1:0] cmd_q;
   logic               pend_q, host_txn_q;
   logic               sel_q, poll_q, bb_q;
   logic [4:0]         preg_q, pphy_q;
   logic [DATA_W-1:0]  mask_q;
   logic               bbclk_q, bbdat_q, bboe_q;

   logic               eng_busy, eng_done, eng_sdo, eng_sdo_en, eng_mdc, eng_start;
   logic [DATA_W-1:0]  eng_rdata, img, chg;
   logic [FRAME_W-1:0] eng_word;
   logic               start_host, start_poll, poll_done, mask_wr, pstat_rd;

   assign start_host = pend_q && !bb_q && !eng_busy;
   assign start_poll = poll_q && !pend_q && !bb_q && !eng_busy;
   assign eng_start  = start_host || start_poll;
   assign eng_word   = start_host ? cmd_q : poll_frame(pphy_q, preg_q);
   assign poll_done  = eng_done && !host_txn_q;
   assign mask_wr    = host_wr && (host_addr == A_PMASK);
   assign pstat_rd   = host_rd && (host_addr == A_PSTAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q      <= FRAME_W'(1) << DONE_BIT;
         pend_q     <= 1'b0;
         host_txn_q <= 1'b0;
         sel_q      <= 1'b0;
         poll_q     <= 1'b0;
         bb_q       <= 1'b0;
         preg_q     <= '0;
         pphy_q     <= '0;
         mask_q     <= '1;
         bbclk_q    <= 1'b0;
         bbdat_q    <= 1'b1;
         bboe_q     <= 1'b0;
      end else begin
         if (eng_start) begin
            host_txn_q <= start_host;
            if (start_host) pend_q <= 1'b0;
         end
         if (eng_done && host_txn_q) begin
            cmd_q[DONE_BIT] <= 1'b1;
            if (cmd_q[29:28] == OP_READ) cmd_q[DATA_W-1:0] <= eng_rdata;
         end
         if (host_wr) begin
            unique case (host_addr)
               A_CMD: begin
                  cmd_q  <= {host_wdata[31:DONE_BIT+1], 1'b0, host_wdata[DONE_BIT-1:0]};
                  pend_q <= 1'b1;
               end
               A_CFG: begin
                  sel_q  <= host_wdata[0];
                  poll_q <= host_wdata[1];
                  bb_q   <= host_wdata[2];
                  preg_q <= host_wdata[7:3];
                  pphy_q <= host_wdata[14:10];
               end
               A_PMASK: mask_q  <= host_wdata[DATA_W-1:0];
               A_BBCLK: bbclk_q <= host_wdata[0];
               A_BBDAT: bbdat_q <= host_wdata[0];
               A_BBOE:  bboe_q  <= host_wdata[0];
               default: ;
            endcase
         end
      end
   end

   mdio_frame_eng #(.HALF_DIV(HALF_DIV), .PRE_BITS(PRE_BITS)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (eng_start),
      .cmd_word(eng_word),
      .sdi     (mdio_i[sel_q]),
      .busy    (eng_busy),
      .done    (eng_done),
      .rd_data (eng_rdata),
      .sdo     (eng_sdo),
      .sdo_en  (eng_sdo_en),
      .mdc     (eng_mdc)
   );

   mdio_poll_trk #(.DW(DATA_W)) u_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (poll_q),
      .res_valid(poll_done),
      .res_data (eng_rdata),
      .clr_rd   (pstat_rd),
      .image    (img),
      .chg      (chg)
   );

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic mine;
      assign mine       = (sel_q == p[0]);
      assign mdio_o[p]  = !mine ? 1'b1 : (bb_q ? bbdat_q : eng_sdo);
      assign mdio_oe[p] = mine && (bb_q ? bboe_q : eng_sdo_en);
   end

   assign mdc = bb_q ? bbclk_q : eng_mdc;
   assign irq = |(chg & ~mask_q);

   always_comb begin
      host_rdata = '0;
      unique case (host_addr)
         A_CMD:   host_rdata = cmd_q;
         A_CFG:   host_rdata = {17'b0, pphy_q, mdio_i[1], mdio_i[0], preg_q, bb_q, poll_q, sel_q};
         A_PSTAT: host_rdata = {img, chg};
         A_PMASK: host_rdata = {16'b0, mask_q};
         A_BBCLK: host_rdata = {31'b0, bbclk_q};
         A_BBDAT: host_rdata = {31'b0, bbdat_q};
         A_BBOE:  host_rdata = {31'b0, bboe_q};
         default: host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mdio_ctrl_chk.sv
`timescale 1ns/1ps
module mdio_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mdc,
   input logic [1:0] mdio_o,
   input logic [1:0] mdio_oe,
   input logic       irq,
   input logic       bb_mode,
   input logic       eng_busy,
   input logic       poll_done,
   input logic       mask_wr
);
   // R6
   one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mdio_oe) <= 1);

   // R4
   data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bb_mode && $past(!bb_mode) && eng_busy && $past(eng_busy) && (mdio_o != $past(mdio_o)))
      |-> $fell(mdc));

   // R5
   idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bb_mode && !eng_busy) |-> !mdc);

   // R9
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(poll_done) || $past(mask_wr)));

   // R11
   no_frame_in_bb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bb_mode && $past(bb_mode)) |-> !$rose(eng_busy));
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mdc      (mdc),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe),
   .irq      (irq),
   .bb_mode  (bb_q),
   .eng_busy (eng_busy),
   .poll_done(poll_done),
   .mask_wr  (mask_wr)
);

// File: tb/tb_mdio_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_ctrl;
   import mdio_pkg::*;
   localparam int HALF = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  host_addr = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        irq, mdc;
   logic [1:0]  mdio_o, mdio_oe, mdio_i;
   logic [1:0]  phy_drv = 2'b11, force0 = 2'b00;

   assign mdio_i = phy_drv & ~force0;
   always #2.5 clk = ~clk;

   mdio_ctrl #(.HALF_DIV(HALF), .PRE_BITS(32)) dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq(irq), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   int total = 0, bad = 0, cyc = 0;
   int r3_err = 0, r4_err = 0, r5_err = 0, r6_err = 0;
   logic [31:0] exp_q[$];
   logic [15:0] phy_val[2];
   logic        cur_sel = 1'b0;
   bit          bb_test = 0, polling = 0, r10_arm = 0;
   logic [15:0] poll_hdr = '0;
   int          polls_since = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // scoreboard monitor: compare each completed frame with the queue
   task automatic sb_check(input logic [63:0] o);
      logic [31:0] low;
      low = o[31:0];
      chk("R2 preamble", o[63:32], 32'hFFFF_FFFF);
      if (exp_q.size() > 0 && low == exp_q[0]) begin
         void'(exp_q.pop_front());
         total++;
         if (r10_arm) begin
            chk("R10 polls before host frame", polls_since, (polls_since <= 1) ? polls_since : 1);
            r10_arm = 0;
         end
      end else if (polling && low[31:16] == poll_hdr) begin
         polls_since++;
      end else begin
         total++; bad++;
         $display("FAIL R2/R3 frame actual=%h expected=%h", low,
                  (exp_q.size() > 0) ? exp_q[0] : {poll_hdr, 16'h0});
      end
   endtask

   // PHY model, evaluated away from the active edge
   logic        prev_mdc = 0, prev_oe = 0, prev_mdo = 1, cur_read = 0;
   int          bit_cnt = 0, last_rise = 0;
   logic [63:0] obs = '0;
   logic [15:0] rd_word = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!bb_test) begin
            if (mdio_oe[cur_sel] && !prev_oe) begin
               bit_cnt = 0;
               cur_read = 0;
            end
            if (mdc && !prev_mdc) begin
               int k, n;
               logic b;
               k = bit_cnt;
               b = mdio_oe[cur_sel] ? mdio_o[cur_sel] : mdio_i[cur_sel];
               obs = {obs[62:0], b};
               if (k > 0 && (cyc - last_rise) != 2 * HALF) r5_err++;
               last_rise = cyc;
               if (cur_read && k >= 46 && mdio_oe[cur_sel]) r3_err++;
               if (k == 35) cur_read = (obs[1:0] == OP_READ);
               if (k == 46 && cur_read) rd_word = phy_val[cur_sel];
               n = k + 1;
               if (cur_read && n == 47)                  phy_drv[cur_sel] = 1'b0;
               else if (cur_read && n >= 48 && n <= 63)  phy_drv[cur_sel] = rd_word[63 - n];
               else                                      phy_drv[cur_sel] = 1'b1;
               if (k == 63) sb_check(obs);
               bit_cnt = n;
            end
            if (mdc && prev_mdc && mdio_o[cur_sel] != prev_mdo) r4_err++;
         end
         if (mdio_oe[!cur_sel] || !mdio_o[!cur_sel]) r6_err++;
      end
      prev_mdc = mdc;
      prev_oe  = mdio_oe[cur_sel];
      prev_mdo = mdio_o[cur_sel];
   end

   task automatic hwr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hrd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wait_done(output logic [31:0] d);
      for (int i = 0; i < 3000; i++) begin
         hrd(A_CMD, d);
         if (d[DONE_BIT]) break;
      end
   endtask

   function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                      input logic [4:0] ra, input logic [15:0] data);
      return {START_CODE, op, phy, ra, TA_CODE, data};
   endfunction

   initial begin
      logic [31:0] v, w;
      phy_val[0] = '0; phy_val[1] = '0;
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      hrd(A_CMD, v);   chk("R1 cmd reset", v, 32'h0001_0000);
      hrd(A_PMASK, v); chk("R1 mask reset", v, 32'h0000_FFFF);
      chk("R1 mdc", mdc, 0);
      chk("R1 oe", mdio_oe, 2'b00);
      chk("R1 irq", irq, 0);

      // R12 live levels, writes to them ignored
      force0 = 2'b10;
      hrd(A_CFG, v);  chk("R12 levels", v[9:8], 2'b01);
      hwr(A_CFG, 32'h0000_0300);
      hrd(A_CFG, v);  chk("R12 write ignored", v & 32'h3FF, 32'h100);
      force0 = 2'b00;

      // R2 write frame on port 0
      w = mk(OP_WRITE, 5'd5, 5'd3, 16'hBEEF);
      exp_q.push_back(w);
      hwr(A_CMD, w);
      hrd(A_CMD, v);  chk("R2 busy flag", v[DONE_BIT], 0);
      wait_done(v);   chk("R2 done flag", v[DONE_BIT], 1);
      chk("R2 frame seen", exp_q.size(), 0);

      // R3 read frame on port 1 (R4: bits taken on rising MDC)
      cur_sel = 1'b1;
      hwr(A_CFG, 32'h1);
      phy_val[1] = 16'hA5C3;
      w = mk(OP_READ, 5'd2, 5'd7, 16'h0);
      exp_q.push_back({w[31:16], 16'hA5C3});
      hwr(A_CMD, w);
      wait_done(v);
      chk("R3 read data", v[16:0], 17'h1A5C3);
      chk("R3 frame seen", exp_q.size(), 0);
      chk("R3 driver released", r3_err, 0);

      // R7 R8 R9 poll mode on port 0
      cur_sel = 1'b0;
      phy_val[0] = 16'h1234;
      poll_hdr = mk(OP_READ, 5'd9, 5'd4, 16'h0) >> 16;
      polling = 1;
      hwr(A_CFG, (32'd9 << 10) | (32'd4 << 3) | 32'h2);
      repeat (800) @(posedge clk);
      hrd(A_PSTAT, v); chk("R7 image first", v, 32'h1234_0000);
      chk("R9 irq masked reset", irq, 0);
      hwr(A_PMASK, 32'hFF00);
      phy_val[0] = 16'h1235;
      repeat (800) @(posedge clk);
      #1 chk("R9 irq unmasked change", irq, 1);
      hrd(A_PSTAT, v); chk("R8 change bit", v, 32'h1235_0001);
      hrd(A_PSTAT, v); chk("R8 cleared on read", v, 32'h1235_0000);
      chk("R9 irq after clear", irq, 0);
      phy_val[0] = 16'h1335;
      repeat (800) @(posedge clk);
      chk("R9 masked change no irq", irq, 0);
      hrd(A_PSTAT, v); chk("R8 masked bit recorded", v, 32'h1335_0100);

      // R10 host command during polling
      w = mk(OP_WRITE, 5'd3, 5'd1, 16'h5A5A);
      polls_since = 0; r10_arm = 1;
      exp_q.push_back(w);
      hwr(A_CMD, w);
      wait_done(v);
      chk("R10 host frame ran", {31'b0, r10_arm}, 0);
      hwr(A_CFG, 32'h0);
      repeat (400) @(posedge clk);
      polling = 0;

      // R11 bit-bang on port 1
      cur_sel = 1'b1; bb_test = 1;
      hwr(A_CFG, 32'h5);
      hwr(A_BBCLK, 32'h1);
      chk("R11 mdc follows reg", mdc, 1);
      hwr(A_BBDAT, 32'h0);
      hwr(A_BBOE, 32'h1);
      chk("R11 data", mdio_o[1], 0);
      chk("R11 enable", mdio_oe, 2'b10);
      w = mk(OP_WRITE, 5'd1, 5'd2, 16'h0F0F);
      hwr(A_CMD, w);
      repeat (40) @(posedge clk);
      hrd(A_CMD, v); chk("R11 command held", v[DONE_BIT], 0);
      chk("R11 mdc untouched", mdc, 1);
      hwr(A_BBCLK, 32'h0);
      hwr(A_BBOE, 32'h0);
      @(negedge clk) bb_test = 0;
      exp_q.push_back(w);
      hwr(A_CFG, 32'h1);
      wait_done(v);
      chk("R11 command after return", v[DONE_BIT], 1);
      chk("R11 frame seen", exp_q.size(), 0);

      chk("R4 data only on falling MDC", r4_err, 0);
      chk("R5 MDC period", r5_err, 0);
      chk("R6 unselected port idle", r6_err, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule